// File: doc/BRIEF.md
# Per-Channel Doorbell Window

This block decodes the host's view of a command engine's pointer registers. Each of 32 channels gets its own 64 KiB page. The channel number sits in address bits 20:16 and the register offset in bits 15:0. An access goes through to the engine only when two conditions hold: the page belongs to the channel the engine is currently serving, and that channel is in DMA submission mode.

Within a page there are three registers:
- offset 0x40 is the put pointer;
- offset 0x44 is the get pointer;
- offset 0x48 is the reference counter.

Reads return the engine's current values. A write to the put pointer updates the engine's register and also rings a doorbell, a one-cycle wake pulse to the pusher. An access to any other channel's page does not complete normally. It raises a context-switch request that carries the requested channel. An access to the active channel while that channel is in PIO mode is refused, as is an access to an offset that maps to nothing. Both set a sticky error flag. In every case the bus handshake still finishes one cycle after the request.

Top module: `chan_doorbell_win`

## Requirements
- R1: While and right after reset, busReady, putWrEn, wakePulse, ctxSwReq and errFlag are 0 and busRData is 0.
- R2: A request is taken when busSel is 1 and busReady is 0. busReady is then 1 for exactly the next cycle, so a select held high completes a transfer every second cycle.
- R3: The requested channel is busAddr[20:16]. It is compared with activeChan, and the channel counts as DMA mode when activeDma is 1.
- R4: A write to offset 0x40 of the active DMA channel drives putWrEn high, with putWrData equal to the written data, in the cycle busReady is high.
- R5: The wake pulse is 1 in exactly the cycle that putWrEn is 1 for an accepted put write, and 0 in the cycle after.
- R6: A read of offset 0x40, 0x44 or 0x48 on the active DMA channel returns engPut, engGet or engRef on busRData while busReady is high. Every write returns 0 on busRData.
- R7: Writes to offsets 0x44 and 0x48 have no effect: no putWrEn, no wake pulse, no context-switch request and no error.
- R8: An access whose channel differs from activeChan raises ctxSwReq for one cycle, together with busReady, with ctxSwChan equal to the requested channel. It returns 0 and neither writes the engine nor sets the error flag.
- R9: An access to the active channel while activeDma is 0 sets errFlag, returns 0 and does not write.
- R10: An access to any offset other than 0x40, 0x44 or 0x48 of the active DMA channel sets errFlag and returns 0.
- R11: Once set, errFlag stays 1 across later good accesses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register-bus request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 21 | Offset into the window (channel in 20:16, register in 15:0) |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Transfer completes |
| activeChan | input | 5 | Channel the engine currently serves |
| activeDma | input | 1 | 1 = active channel uses DMA submission |
| engPut | input | 32 | Engine put pointer |
| engGet | input | 32 | Engine get pointer |
| engRef | input | 32 | Engine reference counter |
| putWrEn | output | 1 | Write strobe for the engine put pointer |
| putWrData | output | 32 | New put pointer value |
| wakePulse | output | 1 | Doorbell to the pusher |
| ctxSwReq | output | 1 | Request to switch to another channel |
| ctxSwChan | output | 5 | Channel named by the switch request |
| errFlag | output | 1 | Sticky rejected-access flag |

## Verification
The decode is tried with reads and writes on the lowest channel, a middle channel and the highest channel. This separates a correct bit-20:16 channel field from a shifted or truncated one, and shows that each of the three offsets reaches the right engine value. Writes to each offset distinguish the doorbell path from the read-only registers. Pages of inactive channels separate the context-switch path from the error path. PIO mode, an unmapped offset and a good access after an error show where the flag is set and that it stays set. A select held high for several cycles shows whether the handshake gaps correctly.

// File: rtl/doorbell_pkg.sv
`timescale 1ns/1ps
package doorbell_pkg;
  localparam logic [15:0] OFF_PUT = 16'h0040;
  localparam logic [15:0] OFF_GET = 16'h0044;
  localparam logic [15:0] OFF_REF = 16'h0048;

  typedef enum logic [1:0] {RD_NONE, RD_PUT, RD_GET, RD_REF} rdSel_e;

  typedef struct packed {
    logic   accept;
    logic   putWrite;
    logic   ctxReq;
    logic   errSet;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/doorbell_ctrl.sv
`timescale 1ns/1ps
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int PAGE_BITS = 16,
  parameter int CHAN_W    = 5,
  localparam int ADDR_W   = PAGE_BITS + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busReady,
  input  logic [CHAN_W-1:0] activeChan,
  input  logic              activeDma,
  output logic [CHAN_W-1:0] reqChan,
  output ctlStrobe_t        strb
);
  logic [PAGE_BITS-1:0] pageOff;

  assign reqChan = busAddr[PAGE_BITS +: CHAN_W];
  assign pageOff = busAddr[PAGE_BITS-1:0];

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_NONE;
    strb.accept   = busSel && !busReady;
    if (strb.accept) begin
      if (reqChan != activeChan) begin
        strb.ctxReq = 1'b1;
      end else if (!activeDma) begin
        strb.errSet = 1'b1;
      end else if (pageOff == PAGE_BITS'(OFF_PUT)) begin
        if (busWr) strb.putWrite = 1'b1;
        else       strb.rdSel    = RD_PUT;
      end else if (pageOff == PAGE_BITS'(OFF_GET)) begin
        if (!busWr) strb.rdSel = RD_GET;
      end else if (pageOff == PAGE_BITS'(OFF_REF)) begin
        if (!busWr) strb.rdSel = RD_REF;
      end else begin
        strb.errSet = 1'b1;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.putWrite, strb.ctxReq, strb.errSet})); // R8
endmodule

// File: rtl/doorbell_dp.sv
`timescale 1ns/1ps
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [DATA_W-1:0] busWData,
  input  logic [DATA_W-1:0] engPut,
  input  logic [DATA_W-1:0] engGet,
  input  logic [DATA_W-1:0] engRef,
  output logic [DATA_W-1:0] busRData,
  output logic              busReady,
  output logic              putWrEn,
  output logic [DATA_W-1:0] putWrData,
  output logic              wakePulse,
  output logic              ctxSwReq,
  output logic [CHAN_W-1:0] ctxSwChan,
  output logic              errFlag
);
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    case (strb.rdSel)
      RD_PUT:  rdMux = engPut;
      RD_GET:  rdMux = engGet;
      RD_REF:  rdMux = engRef;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReady  <= 1'b0;
      busRData  <= '0;
      putWrEn   <= 1'b0;
      putWrData <= '0;
      wakePulse <= 1'b0;
      ctxSwReq  <= 1'b0;
      ctxSwChan <= '0;
      errFlag   <= 1'b0;
    end else begin
      busReady  <= strb.accept;
      putWrEn   <= strb.putWrite;
      wakePulse <= strb.putWrite;
      ctxSwReq  <= strb.ctxReq;
      errFlag   <= errFlag | strb.errSet;
      if (strb.accept)   busRData  <= rdMux;
      if (strb.putWrite) putWrData <= busWData;
      if (strb.ctxReq)   ctxSwChan <= reqChan;
    end
  end

  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> busReady); // R2
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady); // R2
  AST_WAKE_WITH_PUT: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (putWrEn && busReady)); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R5
  AST_CTX_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ctxSwReq |-> (busReady && busRData == '0 && !putWrEn)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R11
endmodule

// File: rtl/chan_doorbell_win.sv
`timescale 1ns/1ps
module chan_doorbell_win
  import doorbell_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 16,
  parameter int CHAN_W    = 5,
  localparam int ADDR_W   = PAGE_BITS + CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              busReady,
  input  logic [CHAN_W-1:0] activeChan,
  input  logic              activeDma,
  input  logic [DATA_W-1:0] engPut,
  input  logic [DATA_W-1:0] engGet,
  input  logic [DATA_W-1:0] engRef,
  output logic              putWrEn,
  output logic [DATA_W-1:0] putWrData,
  output logic              wakePulse,
  output logic              ctxSwReq,
  output logic [CHAN_W-1:0] ctxSwChan,
  output logic              errFlag
);
  ctlStrobe_t        strb;
  logic [CHAN_W-1:0] reqChan;

  doorbell_ctrl #(.PAGE_BITS(PAGE_BITS), .CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busReady(busReady), .activeChan(activeChan), .activeDma(activeDma),
    .reqChan(reqChan), .strb(strb)
  );

  doorbell_dp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqChan(reqChan), .busWData(busWData),
    .engPut(engPut), .engGet(engGet), .engRef(engRef), .busRData(busRData),
    .busReady(busReady), .putWrEn(putWrEn), .putWrData(putWrData),
    .wakePulse(wakePulse), .ctxSwReq(ctxSwReq), .ctxSwChan(ctxSwChan),
    .errFlag(errFlag)
  );
endmodule

// File: tb/tb_chan_doorbell_win.sv
`timescale 1ns/1ps
module tb_chan_doorbell_win;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [20:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        busReady;
  logic [4:0]  activeChan = 5'd3;
  logic        activeDma = 1'b1;
  logic [31:0] engPut = 32'h0000_1000;
  logic [31:0] engGet = 32'h0000_0800;
  logic [31:0] engRef = 32'hCAFE_0001;
  logic        putWrEn, wakePulse, ctxSwReq, errFlag;
  logic [31:0] putWrData;
  logic [4:0]  ctxSwChan;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chan_doorbell_win dut (.*);

  typedef struct packed {
    logic        wr;
    logic [20:0] addr;
    logic [31:0] wdata;
    logic [4:0]  act;
    logic [31:0] expRd;
    logic        expPut;
    logic        expCtx;
    logic [4:0]  expChan;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 21'h03_0040, 32'h0,         5'd3,  32'h0000_1000, 1'b0, 1'b0, 5'd0},
    '{1'b0, 21'h03_0044, 32'h0,         5'd3,  32'h0000_0800, 1'b0, 1'b0, 5'd0},
    '{1'b0, 21'h03_0048, 32'h0,         5'd3,  32'hCAFE_0001, 1'b0, 1'b0, 5'd0},
    '{1'b1, 21'h03_0040, 32'h0000_2040, 5'd3,  32'h0,         1'b1, 1'b0, 5'd0},
    '{1'b1, 21'h03_0044, 32'h1111_1111, 5'd3,  32'h0,         1'b0, 1'b0, 5'd0},
    '{1'b1, 21'h03_0048, 32'h2222_2222, 5'd3,  32'h0,         1'b0, 1'b0, 5'd0},
    '{1'b1, 21'h00_0040, 32'h0000_1234, 5'd0,  32'h0,         1'b1, 1'b0, 5'd0},
    '{1'b0, 21'h1F_0048, 32'h0,         5'd31, 32'hCAFE_0001, 1'b0, 1'b0, 5'd0},
    '{1'b1, 21'h1F_0040, 32'h00AB_CDE0, 5'd31, 32'h0,         1'b1, 1'b0, 5'd0},
    '{1'b0, 21'h05_0040, 32'h0,         5'd3,  32'h0,         1'b0, 1'b1, 5'd5},
    '{1'b1, 21'h02_0040, 32'h0000_5550, 5'd3,  32'h0,         1'b0, 1'b1, 5'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; busSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive at a falling edge; returns at the next falling edge with outputs valid
  task automatic access(input logic wr, input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    #100us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 ready", 32'(busReady), 0);
    check("R1 put", 32'(putWrEn), 0);
    check("R1 wake", 32'(wakePulse), 0);
    check("R1 ctx", 32'(ctxSwReq), 0);
    check("R1 err", 32'(errFlag), 0);
    check("R1 rdata", busRData, 0);
    doReset();

    for (int i = 0; i < NV; i++) begin
      activeChan = VECS[i].act; activeDma = 1'b1;
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      check("R2 ready", 32'(busReady), 1);
      check("R6 rdata", busRData, VECS[i].expRd);
      check("R4 putWrEn", 32'(putWrEn), 32'(VECS[i].expPut));
      check("R5 wake", 32'(wakePulse), 32'(VECS[i].expPut));
      if (VECS[i].expPut) check("R4 putWrData", putWrData, VECS[i].wdata);
      check("R8 ctx", 32'(ctxSwReq), 32'(VECS[i].expCtx));
      if (VECS[i].expCtx) check("R8 ctxChan", 32'(ctxSwChan), 32'(VECS[i].expChan));
      check("R7 err", 32'(errFlag), 0);
      @(negedge clk);
      check("R5 wake single", 32'(wakePulse), 0);
      check("R2 ready drop", 32'(busReady), 0);
    end

    // R3 channel field: active channel 16 must not answer page 0 or page 8
    activeChan = 5'd16;
    access(1'b0, 21'h10_0044, 0);
    check("R3 ch16 get", busRData, 32'h0000_0800);
    access(1'b0, 21'h00_0044, 0);
    check("R3 ch0 ctx", 32'(ctxSwReq), 1);
    access(1'b0, 21'h08_0044, 0);
    check("R3 ch8 ctxChan", 32'(ctxSwChan), 8);

    // R2 held select: transfers every second cycle
    activeChan = 5'd3;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 21'h03_0040;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 held ready", 32'(busReady), 32'((k % 2) == 0));
    end
    busSel = 1'b0;
    @(negedge clk);

    // R9 PIO mode
    activeDma = 1'b0;
    access(1'b1, 21'h03_0040, 32'h0000_7770);
    check("R9 err", 32'(errFlag), 1);
    check("R9 no put", 32'(putWrEn), 0);
    check("R9 ready", 32'(busReady), 1);
    access(1'b0, 21'h03_0040, 0);
    check("R9 rdata", busRData, 0);

    // R11 cleared only by reset
    activeDma = 1'b1;
    doReset();
    check("R11 reset clears", 32'(errFlag), 0);

    // R10 unmapped offset
    access(1'b0, 21'h03_004C, 0);
    check("R10 err", 32'(errFlag), 1);
    check("R10 rdata", busRData, 0);

    // R11 stays set across good access
    access(1'b0, 21'h03_0048, 0);
    check("R11 sticky", 32'(errFlag), 1);
    check("R11 read still ok", busRData, 32'hCAFE_0001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule